// File: doc/BRIEF.md
# Two-Way Set-Associative Tag Store

This block is an associative memory made from two equal storage banks, way A and way B. The low bits of the incoming address pick one set, which is the same row in both banks. Each bank row holds the remaining upper address bits as a tag, a data word and a valid flag. A lookup compares the tag part of the address against both rows of the selected set at once. The `hit` flag and the read data follow the address combinationally, with no clock in the read path.

A write strobe stores the write data under the presented address on the next rising clock edge, and exactly one bank is clocked. If the address already hits, the matching bank is updated in place. If it misses, an empty way of the set is filled, trying way A before way B. When both ways of the set are occupied, a replacement policy picks the bank. A parameter selects the policy:

- **Toggle policy:** a single global bit flips on every write and names the bank.
- **Per-set recency policy:** one bit per set records which way was used most recently by a read hit or a write, and the other way is replaced.

When both ways match, way B has priority for the read data and for the write.

Top module: `assoc2_tagstore`

## Requirements
- R1: After reset every entry in both ways is invalid, so `hit` is 0 for every address until something is written.
- R2: After a write on a rising edge, presenting the same address gives `hit`=1 and `rdData` equal to the written word, combinationally and without a further clock.
- R3: The set index is the low INDEX_W address bits (10 by default) and the tag is the upper ADDR_W-INDEX_W bits. Two addresses with the same index and different tags can be held at once. An address with a different index does not hit on entries of another set.
- R4: A write whose address hits clocks only the way that holds the tag. Its data is replaced and the entry in the other way of the set is kept. Every write clocks exactly one bank.
- R5: A write that misses fills way A when A's entry in that set is invalid. Otherwise it fills way B when B's entry is invalid. Only when both are valid is the replacement policy consulted.
- R6: With LRU_MODE=0, a global toggle bit resets to 0 and inverts on every write, hit or miss. A miss into a full set replaces way A when the bit is 0 and way B when it is 1.
- R7: With LRU_MODE=1, each set keeps a bit naming the way used last. A write updates it to the way written. A cycle with `rdEn`=1, `wrEn`=0 and a hit updates it to the way that hit. A miss into a full set replaces the way not named by the bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset; clears valid flags and policy state |
| addrIn | input | ADDR_W | Full lookup and write address |
| wrData | input | DATA_W | Word to store on a write |
| wrEn | input | 1 | Write strobe; the write takes place at the next rising edge |
| rdEn | input | 1 | Marks the cycle as a read, so that a hit updates the recency bit |
| rdData | output | DATA_W | Data of the matching way (way B when both match) |
| hit | output | 1 | 1 when a valid entry in either way of the set holds the address tag |

## Verification
The bench sends the same stream of writes and reads to one instance of each policy. It fills one set beyond capacity several times, so that the two policies evict different addresses. A toggle bit that skipped write hits, or a recency bit that ignored read hits, would evict the wrong address, and a later read would report a hit where a miss is expected or the reverse. A write hit that allocated a fresh way instead of updating in place would leave stale data visible. A fill that ignored the valid flags would evict a live entry while an empty way remains. Directed cases at the extreme index and tag values catch index and tag bits that are taken from the wrong place, and a second reset shows that all entries are invalidated.

// File: rtl/assoc2_pkg.sv
package assoc2_pkg;

  localparam int NUM_WAYS = 2;
  localparam int WAY_A    = 0;
  localparam int WAY_B    = 1;

  // strobes from control to datapath
  typedef struct packed {
    logic wrA;   // clock way A this cycle
    logic wrB;   // clock way B this cycle
    logic selB;  // steer read data from way B
  } bankCtl_t;

endpackage

// File: rtl/assoc2_bank.sv
module assoc2_bank #(
  parameter int INDEX_W = 10,
  parameter int TAG_W   = 22,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [INDEX_W-1:0] setIdx,
  input  logic [TAG_W-1:0]   tagIn,
  input  logic [DATA_W-1:0]  dataIn,
  input  logic               wrStrobe,
  output logic               tagMatch,
  output logic               entryValid,
  output logic [DATA_W-1:0]  dataOut
);

  localparam int SETS = 1 << INDEX_W;

  logic [SETS-1:0]   validQ;
  logic [TAG_W-1:0]  tagMem  [SETS];
  logic [DATA_W-1:0] dataMem [SETS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
    end else if (wrStrobe) begin
      validQ[setIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wrStrobe) begin
      tagMem[setIdx]  <= tagIn;
      dataMem[setIdx] <= dataIn;
    end
  end

  assign entryValid = validQ[setIdx];
  assign tagMatch   = entryValid && (tagMem[setIdx] == tagIn);
  assign dataOut    = dataMem[setIdx];

endmodule

// File: rtl/assoc2_datapath.sv
module assoc2_datapath
  import assoc2_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int INDEX_W = 10,
  parameter int DATA_W  = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addrIn,
  input  logic [DATA_W-1:0]   wrData,
  input  bankCtl_t            ctl,
  output logic [NUM_WAYS-1:0] wayMatch,
  output logic [NUM_WAYS-1:0] wayValid,
  output logic [DATA_W-1:0]   rdData
);

  localparam int TAG_W = ADDR_W - INDEX_W;

  logic [INDEX_W-1:0] setIdx;
  logic [TAG_W-1:0]   tagPart;
  logic [DATA_W-1:0]  wayData [NUM_WAYS];
  logic [NUM_WAYS-1:0] wayStrobe;

  assign setIdx  = addrIn[INDEX_W-1:0];
  assign tagPart = addrIn[ADDR_W-1:INDEX_W];

  assign wayStrobe[WAY_A] = ctl.wrA;
  assign wayStrobe[WAY_B] = ctl.wrB;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assoc2_bank #(
      .INDEX_W(INDEX_W),
      .TAG_W  (TAG_W),
      .DATA_W (DATA_W)
    ) u_bank (
      .clk       (clk),
      .rstN      (rstN),
      .setIdx    (setIdx),
      .tagIn     (tagPart),
      .dataIn    (wrData),
      .wrStrobe  (wayStrobe[w]),
      .tagMatch  (wayMatch[w]),
      .entryValid(wayValid[w]),
      .dataOut   (wayData[w])
    );
  end

  // way B wins the output mux whenever its tag matches
  assign rdData = ctl.selB ? wayData[WAY_B] : wayData[WAY_A];

endmodule

// File: rtl/assoc2_control.sv
module assoc2_control
  import assoc2_pkg::*;
#(
  parameter int INDEX_W  = 10,
  parameter bit LRU_MODE = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [INDEX_W-1:0]  setIdx,
  input  logic [NUM_WAYS-1:0] wayMatch,
  input  logic [NUM_WAYS-1:0] wayValid,
  output bankCtl_t            ctl,
  output logic                hit
);

  localparam int SETS = 1 << INDEX_W;

  logic victimB;   // policy choice for a full set
  logic fillB;     // bank chosen on a miss
  logic writeB;    // bank chosen for this write

  assign hit = |wayMatch;

  always_comb begin
    if (!wayValid[WAY_A])      fillB = 1'b0;
    else if (!wayValid[WAY_B]) fillB = 1'b1;
    else                       fillB = victimB;
  end

  // a hit picks the matching way, B first if both match
  assign writeB   = hit ? wayMatch[WAY_B] : fillB;
  assign ctl.wrB  = wrEn && writeB;
  assign ctl.wrA  = wrEn && !writeB;
  assign ctl.selB = wayMatch[WAY_B];

  if (LRU_MODE) begin : g_lru
    logic [SETS-1:0] mruB;  // 1: way B used most recently in this set

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        mruB <= '0;
      end else if (wrEn) begin
        mruB[setIdx] <= writeB;
      end else if (rdEn && hit) begin
        mruB[setIdx] <= wayMatch[WAY_B];
      end
    end

    assign victimB = !mruB[setIdx];
  end else begin : g_toggle
    logic toggleQ;
    logic unusedInputs;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)     toggleQ <= 1'b0;
      else if (wrEn) toggleQ <= !toggleQ;
    end

    assign victimB      = toggleQ;
    assign unusedInputs = ^{rdEn, setIdx};
  end

endmodule

// File: rtl/assoc2_tagstore.sv
module assoc2_tagstore
  import assoc2_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int INDEX_W  = 10,
  parameter int DATA_W   = 32,
  parameter bit LRU_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              hit
);

  bankCtl_t            ctl;
  logic [NUM_WAYS-1:0] wayMatch;
  logic [NUM_WAYS-1:0] wayValid;

  assoc2_datapath #(
    .ADDR_W (ADDR_W),
    .INDEX_W(INDEX_W),
    .DATA_W (DATA_W)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .addrIn  (addrIn),
    .wrData  (wrData),
    .ctl     (ctl),
    .wayMatch(wayMatch),
    .wayValid(wayValid),
    .rdData  (rdData)
  );

  assoc2_control #(
    .INDEX_W (INDEX_W),
    .LRU_MODE(LRU_MODE)
  ) u_control (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .setIdx  (addrIn[INDEX_W-1:0]),
    .wayMatch(wayMatch),
    .wayValid(wayValid),
    .ctl     (ctl),
    .hit     (hit)
  );

endmodule

// File: rtl/assoc2_tagstore_chk.sv
module assoc2_tagstore_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addrIn,
  input logic [DATA_W-1:0] wrData,
  input logic              wrEn,
  input logic [DATA_W-1:0] rdData,
  input logic              hit,
  input logic              bankWrA,
  input logic              bankWrB,
  input logic              validA,
  input logic              validB
);

  assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !hit);

  assert_write_visible_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> ((addrIn != $past(addrIn)) || (hit && rdData == $past(wrData))));

  assert_one_bank_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> $countones({bankWrA, bankWrB}) == 1);

  assert_idle_no_bank_R4: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> !(bankWrA || bankWrB));

  assert_fill_a_first_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !hit && !validA) |-> bankWrA);

  assert_fill_b_next_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !hit && validA && !validB) |-> bankWrB);

endmodule

bind assoc2_tagstore assoc2_tagstore_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .addrIn (addrIn),
  .wrData (wrData),
  .wrEn   (wrEn),
  .rdData (rdData),
  .hit    (hit),
  .bankWrA(ctl.wrA),
  .bankWrB(ctl.wrB),
  .validA (wayValid[0]),
  .validB (wayValid[1])
);

// File: tb/assoc2_tagstore_tb.sv
`timescale 1ns/1ps
module assoc2_tagstore_tb;

  localparam int ADDR_W  = 32;
  localparam int INDEX_W = 10;
  localparam int DATA_W  = 32;
  localparam int TAG_W   = ADDR_W - INDEX_W;

  typedef struct packed {
    logic              isWr;
    logic [TAG_W-1:0]  tag;
    logic [INDEX_W-1:0] idx;
    logic [DATA_W-1:0] data;   // write word, or expected word on a read
    logic              expT;   // expected hit, toggle instance
    logic              expL;   // expected hit, recency instance
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 22'h1, 10'd5, 32'hD000_0001, 1'b0, 1'b0}, // 0 W t1 fills A (R5)
    '{1'b1, 22'h2, 10'd5, 32'hD000_0002, 1'b0, 1'b0}, // 1 W t2 fills B (R5)
    '{1'b0, 22'h1, 10'd5, 32'hD000_0001, 1'b1, 1'b1}, // 2 R t1, recency -> A (R3)
    '{1'b1, 22'h3, 10'd5, 32'hD000_0003, 1'b0, 1'b0}, // 3 W t3: tog evicts A, rec evicts B
    '{1'b0, 22'h1, 10'd5, 32'hD000_0001, 1'b0, 1'b1}, // 4
    '{1'b0, 22'h2, 10'd5, 32'hD000_0002, 1'b1, 1'b0}, // 5
    '{1'b0, 22'h3, 10'd5, 32'hD000_0003, 1'b1, 1'b1}, // 6 recency -> B
    '{1'b1, 22'h4, 10'd5, 32'hD000_0004, 1'b0, 1'b0}, // 7 W t4: tog evicts B(t2), rec evicts A(t1)
    '{1'b0, 22'h2, 10'd5, 32'hD000_0002, 1'b0, 1'b0}, // 8
    '{1'b0, 22'h1, 10'd5, 32'hD000_0001, 1'b0, 1'b0}, // 9
    '{1'b0, 22'h4, 10'd5, 32'hD000_0004, 1'b1, 1'b1}, // 10
    '{1'b1, 22'h3, 10'd5, 32'hD000_0006, 1'b1, 1'b1}, // 11 W hit t3 in place (R4)
    '{1'b0, 22'h3, 10'd5, 32'hD000_0006, 1'b1, 1'b1}, // 12 new data (R4)
    '{1'b1, 22'h5, 10'd5, 32'hD000_0005, 1'b0, 1'b0}, // 13 W t5: both evict t4
    '{1'b0, 22'h4, 10'd5, 32'hD000_0004, 1'b0, 1'b0}, // 14
    '{1'b0, 22'h5, 10'd5, 32'hD000_0005, 1'b1, 1'b1}, // 15
    '{1'b0, 22'h3, 10'd5, 32'hD000_0006, 1'b1, 1'b1}, // 16 kept (R4)
    '{1'b0, 22'h1, 10'd6, 32'hD000_0001, 1'b0, 1'b0}  // 17 other set (R3)
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic              wrEn = 1'b0;
  logic              rdEn = 1'b0;
  logic [DATA_W-1:0] rdDataT, rdDataL;
  logic              hitT, hitL;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  assoc2_tagstore #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .DATA_W(DATA_W), .LRU_MODE(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .wrData(wrData),
    .wrEn(wrEn), .rdEn(rdEn), .rdData(rdDataT), .hit(hitT));

  assoc2_tagstore #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .DATA_W(DATA_W), .LRU_MODE(1'b1)) u_dut_lru (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .wrData(wrData),
    .wrEn(wrEn), .rdEn(rdEn), .rdData(rdDataL), .hit(hitL));

  task automatic checkVal(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one operation per clock: inputs set after a falling edge, reads sampled before the rising edge
  task automatic doOp(input logic isWr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    addrIn = a;
    wrData = d;
    wrEn   = isWr;
    rdEn   = !isWr;
    #2;
    @(posedge clk);
  endtask

  task automatic readCheck(input string req, input logic [ADDR_W-1:0] a,
                           input logic expT, input logic expL, input logic [DATA_W-1:0] expD);
    @(negedge clk);
    addrIn = a;
    wrEn   = 1'b0;
    rdEn   = 1'b1;
    #2;
    checkVal({req, " hit toggle"}, {31'd0, hitT}, {31'd0, expT});
    checkVal({req, " hit recency"}, {31'd0, hitL}, {31'd0, expL});
    if (expT) checkVal({req, " data toggle"}, rdDataT, expD);
    if (expL) checkVal({req, " data recency"}, rdDataL, expD);
    @(posedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: nothing hits after reset
    readCheck("R1", {22'h1, 10'd5}, 1'b0, 1'b0, '0);
    readCheck("R1", {22'h0, 10'd0}, 1'b0, 1'b0, '0);
    readCheck("R1", {22'h3FFFFF, 10'h3FF}, 1'b0, 1'b0, '0);

    // shared stream; toggle instance checks R6, recency instance R7
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].isWr) doOp(1'b1, {VEC[i].tag, VEC[i].idx}, VEC[i].data);
      else readCheck("R6/R7", {VEC[i].tag, VEC[i].idx}, VEC[i].expT, VEC[i].expL, VEC[i].data);
    end

    // R2/R3: extreme index and tag values
    doOp(1'b1, {22'h3FFFFF, 10'h3FF}, 32'hCAFE_F00D);
    readCheck("R2", {22'h3FFFFF, 10'h3FF}, 1'b1, 1'b1, 32'hCAFE_F00D);
    readCheck("R3", {22'h3FFFFF, 10'h000}, 1'b0, 1'b0, '0);
    readCheck("R3", {22'h1FFFFF, 10'h3FF}, 1'b0, 1'b0, '0);
    doOp(1'b1, {22'h000000, 10'h000}, 32'h0BAD_BEEF);
    readCheck("R2", {22'h000000, 10'h000}, 1'b1, 1'b1, 32'h0BAD_BEEF);

    // R1: a second reset invalidates stored entries
    @(negedge clk);
    wrEn = 1'b0;
    rdEn = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    readCheck("R1", {22'h3, 10'd5}, 1'b0, 1'b0, '0);
    readCheck("R1", {22'h3FFFFF, 10'h3FF}, 1'b0, 1'b0, '0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule